// File: doc/BRIEF.md
# Register Access Transaction Sequencer

This block runs one register read or write over a serial slave link. It takes a 23-bit flat register address, packs it into a command word and hands the frame to a separate bit-level transmitter. When the transmitter finishes, the block starts a separate response receiver. If the slave answers busy, the block sends a short poll frame and listens again. It keeps doing this until the slave gives a final answer or the poll limit runs out.

Only one transaction is open at a time. The requester presents the address, direction and write data with a valid strobe. It then waits for a one-cycle done strobe, which carries the final status and, for a successful read, the 32 data bits. Serial bit timing and the frame check sequence belong to the transmitter and receiver. They are not part of this block.

Top module: `xact_seq`

## Requirements
- R1: `req_ready` is high when idle. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle after the `rsp_done` pulse.
- R2: The command word is 28 bits, sent at `tx_frame[63:36]`. It is built as follows:
  - Bits 27:26 hold address bits 22:21.
  - Bits 25:22 hold 4'b100r, where r is 1 for a read.
  - Bits 21:0 hold ((address bits 20:8 kept in place) OR (address bits 7:0 shifted left by 2)), shifted left by 1, with bits 1:0 forced to 1.
- R3: A read sends `tx_len` = 28 and requests `rx_len` = 32 response data bits, for the command frame and for every poll.
- R4: A write sends `tx_len` = 60, with the 32 write data bits at `tx_frame[35:4]`, and requests `rx_len` = 0.
- R5: `tx_start` is a one-cycle pulse in the cycle after a request is accepted. `rx_start` is a one-cycle pulse in the cycle after `tx_done` is seen, and never before.
- R6: A busy response (`rx_status` = 1) causes a poll frame with `tx_len` = 5 and `tx_frame[63:59]` = 5'b00010 (slave 0, poll code 2).
- R7: At most MAX_POLLS (default 512) poll frames follow one command. If the last of them is also answered busy, the transaction ends with status busy (1).
- R8: A receiver timeout (4) or check error (5) ends the transaction in the next cycle with that status, and no further frame is sent. Slave errors (2, 3) and ack (0) also end it.
- R9: `rsp_data` equals `rx_data` for a read that ends in ack. It is zero for writes and for any failed transaction.
- R10: `rsp_err` is high with `rsp_done` whenever `rsp_status` is not ack (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block is idle and can take a request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 23 | Flat register address |
| req_wdata | input | 32 | Write data |
| tx_start | output | 1 | Start pulse to the frame transmitter |
| tx_frame | output | 64 | Frame bits, MSB first, left aligned |
| tx_len | output | 7 | Number of frame bits to send |
| tx_done | input | 1 | Transmitter finished the frame |
| rx_start | output | 1 | Start pulse to the response receiver |
| rx_len | output | 6 | Response data bits expected |
| rx_done | input | 1 | Receiver finished, status valid |
| rx_status | input | 3 | 0 ack, 1 busy, 2 slave error A, 3 slave error C, 4 timeout, 5 check error |
| rx_data | input | 32 | Received data bits |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_status | output | 3 | Final status, same coding as rx_status |
| rsp_err | output | 1 | Final status is not ack |
| rsp_data | output | 32 | Read result |

## Verification
The assertions assume the following about the inputs:
- `tx_done` and `rx_done` arrive only while the block is waiting for them.
- `req_valid` is dropped once the request is accepted.
- `rx_status` holds one of the six defined codes whenever `rx_done` is high.

The stimulus plays the transmitter and receiver from a single sequential task. That task raises each done pulse only after it has seen the matching start pulse. It releases the request one cycle after acceptance and returns only defined status codes.

// File: rtl/xact_seq_pkg.sv
package xact_seq_pkg;
    typedef enum logic [2:0] {
        ST_ACK     = 3'd0,
        ST_BUSY    = 3'd1,
        ST_ERR_A   = 3'd2,
        ST_ERR_C   = 3'd3,
        ST_TIMEOUT = 3'd4,
        ST_CHKERR  = 3'd5
    } xstat_e;

    typedef enum logic [2:0] {
        S_IDLE, S_TX_GO, S_TX_WAIT, S_RX_GO, S_RX_WAIT, S_FIN
    } phase_e;

    localparam int CMD_BITS  = 28;
    localparam int POLL_BITS = 5;
    localparam logic [4:0] POLL_CODE = 5'b00010;
endpackage

// File: rtl/xact_fmt.sv
module xact_fmt #(
    parameter int ADDR_W  = 23,
    parameter int DATA_W  = 32,
    parameter int FRAME_W = 64
) (
    input  logic               is_read,
    input  logic               is_poll,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [FRAME_W-1:0] frame,
    output logic [6:0]         frame_len,
    output logic [5:0]         resp_len
);
    import xact_seq_pkg::*;

    localparam int LOW_W = CMD_BITS - 6;

    logic [LOW_W-2:0]    merged;
    logic [LOW_W-1:0]    low_part;
    logic [CMD_BITS-1:0] cmd;

    always_comb begin
        merged   = {addr[20:8], 8'h00} | {11'd0, addr[7:0], 2'b00};
        low_part = {merged, 1'b0} | LOW_W'(3);
        cmd      = {addr[22:21], 1'b1, 2'b00, is_read, low_part};
        frame    = '0;
        if (is_poll) begin
            frame[FRAME_W-1 -: POLL_BITS] = POLL_CODE;
            frame_len = 7'(POLL_BITS);
        end else begin
            frame[FRAME_W-1 -: CMD_BITS] = cmd;
            if (!is_read) frame[FRAME_W-CMD_BITS-1 -: DATA_W] = wdata;
            frame_len = is_read ? 7'(CMD_BITS) : 7'(CMD_BITS + DATA_W);
        end
        resp_len = is_read ? 6'(DATA_W) : 6'd0;
    end
endmodule

// File: rtl/xact_ctrl.sv
module xact_ctrl #(
    parameter int ADDR_W    = 23,
    parameter int DATA_W    = 32,
    parameter int MAX_POLLS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_read,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              tx_start,
    input  logic              tx_done,
    output logic              rx_start,
    input  logic              rx_done,
    input  logic [2:0]        rx_status,
    input  logic [DATA_W-1:0] rx_data,
    output logic              lat_read,
    output logic              lat_poll,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              rsp_done,
    output logic [2:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_data
);
    import xact_seq_pkg::*;

    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    typedef struct packed {
        phase_e            phase;
        logic              rd;
        logic              poll;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [CNT_W-1:0]  polls;
        logic [2:0]        status;
        logic [DATA_W-1:0] data;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            S_IDLE: if (req_valid) begin
                st_d.phase = S_TX_GO;
                st_d.rd    = req_read;
                st_d.addr  = req_addr;
                st_d.wdata = req_wdata;
                st_d.poll  = 1'b0;
                st_d.polls = '0;
            end
            S_TX_GO:   st_d.phase = S_TX_WAIT;
            S_TX_WAIT: if (tx_done) st_d.phase = S_RX_GO;
            S_RX_GO:   st_d.phase = S_RX_WAIT;
            S_RX_WAIT: if (rx_done) begin
                if (rx_status == ST_BUSY && st_q.polls < CNT_W'(MAX_POLLS)) begin
                    st_d.phase = S_TX_GO;
                    st_d.poll  = 1'b1;
                    st_d.polls = st_q.polls + 1'b1;
                end else begin
                    st_d.phase  = S_FIN;
                    st_d.status = rx_status;
                    st_d.data   = (st_q.rd && rx_status == ST_ACK) ? rx_data : '0;
                end
            end
            S_FIN:   st_d.phase = S_IDLE;
            default: st_d.phase = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = (st_q.phase == S_IDLE);
    assign tx_start   = (st_q.phase == S_TX_GO);
    assign rx_start   = (st_q.phase == S_RX_GO);
    assign rsp_done   = (st_q.phase == S_FIN);
    assign rsp_status = st_q.status;
    assign rsp_data   = st_q.data;
    assign lat_read   = st_q.rd;
    assign lat_poll   = st_q.poll;
    assign lat_addr   = st_q.addr;
    assign lat_wdata  = st_q.wdata;

    // R1: accepting a request starts the command and closes the door
    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && tx_start);
    // R1: ready returns right after the done strobe
    a_r1_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> req_ready);
    // R5: receiver is started only after the transmitter reported done
    a_r5_rx_after_tx: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |-> $past(tx_done));
    // R7: poll counter never passes its limit
    a_r7_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.polls <= CNT_W'(MAX_POLLS));
    // R8: link faults end the transaction at once with the same code
    a_r8_fault_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == S_RX_WAIT) && rx_done &&
        (rx_status == ST_TIMEOUT || rx_status == ST_CHKERR)
        |=> rsp_done && rsp_status == $past(rx_status));
endmodule

// File: rtl/xact_seq.sv
module xact_seq #(
    parameter int ADDR_W    = 23,
    parameter int DATA_W    = 32,
    parameter int FRAME_W   = 64,
    parameter int MAX_POLLS = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_read,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               tx_start,
    output logic [FRAME_W-1:0] tx_frame,
    output logic [6:0]         tx_len,
    input  logic               tx_done,
    output logic               rx_start,
    output logic [5:0]         rx_len,
    input  logic               rx_done,
    input  logic [2:0]         rx_status,
    input  logic [DATA_W-1:0]  rx_data,
    output logic               rsp_done,
    output logic [2:0]         rsp_status,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_data
);
    logic              lat_read, lat_poll;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;

    xact_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_POLLS(MAX_POLLS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .tx_start(tx_start), .tx_done(tx_done),
        .rx_start(rx_start), .rx_done(rx_done), .rx_status(rx_status), .rx_data(rx_data),
        .lat_read(lat_read), .lat_poll(lat_poll), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
        .rsp_done(rsp_done), .rsp_status(rsp_status), .rsp_data(rsp_data)
    );

    xact_fmt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_fmt (
        .is_read(lat_read), .is_poll(lat_poll), .addr(lat_addr), .wdata(lat_wdata),
        .frame(tx_frame), .frame_len(tx_len), .resp_len(rx_len)
    );

    assign rsp_err = rsp_done && (rsp_status != 3'd0);

    // R6: every short frame carries the poll code
    a_r6_poll_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start && tx_len == 7'd5 |-> tx_frame[FRAME_W-1 -: 5] == 5'b00010);
    // R10: error flag tracks the final status
    a_r10_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done && rsp_status != 3'd0 |-> rsp_err);
endmodule

// File: tb/xact_seq_test.sv
module xact_seq_test;
    localparam int MAXP = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_read = 1'b0;
    logic [22:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        tx_start, req_ready, rx_start, rsp_done, rsp_err;
    logic [63:0] tx_frame;
    logic [6:0]  tx_len;
    logic [5:0]  rx_len;
    logic        tx_done = 1'b0, rx_done = 1'b0;
    logic [2:0]  rx_status = '0, rsp_status;
    logic [31:0] rx_data = '0, rsp_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    xact_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
        .tx_start(tx_start), .tx_frame(tx_frame), .tx_len(tx_len), .tx_done(tx_done),
        .rx_start(rx_start), .rx_len(rx_len), .rx_done(rx_done), .rx_status(rx_status),
        .rx_data(rx_data), .rsp_done(rsp_done), .rsp_status(rsp_status),
        .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    typedef struct packed {
        logic        rd;
        logic [22:0] addr;
        logic [31:0] wdata;
        logic [9:0]  nbusy;
        logic [2:0]  fin;
        logic [31:0] rdata;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 23'h000800, 32'h0,        10'd0, 3'd0, 32'hDEADBEEF},
        '{1'b0, 23'h7FFFFF, 32'h12345678, 10'd0, 3'd0, 32'h0},
        '{1'b1, 23'h2000A5, 32'h0,        10'd3, 3'd0, 32'hCAFEF00D},
        '{1'b0, 23'h0001FF, 32'hFFFF0000, 10'd2, 3'd2, 32'h0},
        '{1'b1, 23'h412345, 32'h0,        10'd0, 3'd4, 32'h5555AAAA},
        '{1'b1, 23'h001234, 32'h0,        10'd1, 3'd5, 32'h11112222},
        '{1'b1, 23'h300003, 32'h0,        10'd0, 3'd3, 32'h77777777}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [27:0] exp_cmd(input logic rd, input logic [22:0] a);
        logic [20:0] m;
        logic [27:0] w;
        m = (a[20:0] & 21'h1FFF00) | (21'(a[7:0]) << 2);
        w = 28'(m) << 1;
        w = w | 28'd3;
        w = w | (28'(a[22:21]) << 26) | (28'(4'h8 | 4'(rd)) << 22);
        return w;
    endfunction

    task automatic run_xact(input vec_t v);
        int nf;
        int extra_tx;
        logic [2:0] exp_st;
        logic [31:0] exp_dat;
        nf = (v.nbusy > MAXP) ? MAXP + 1 : int'(v.nbusy) + 1;
        exp_st  = (v.nbusy > MAXP) ? 3'd1 : v.fin;
        exp_dat = (v.rd && exp_st == 3'd0) ? v.rdata : 32'h0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_read = v.rd; req_addr = v.addr; req_wdata = v.wdata;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1 ready low while busy", 64'(req_ready), 64'd0);
        chk(tx_start == 1'b1, "R5 tx_start after accept", 64'(tx_start), 64'd1);
        for (int f = 0; f < nf; f++) begin
            for (int w = 0; w < 20 && !tx_start; w++) @(negedge clk);
            if (f == 0) begin
                chk(tx_frame[63:36] == exp_cmd(v.rd, v.addr), "R2 command word",
                    64'(tx_frame[63:36]), 64'(exp_cmd(v.rd, v.addr)));
                if (v.rd) begin
                    chk(tx_len == 7'd28, "R3 read frame length", 64'(tx_len), 64'd28);
                end else begin
                    chk(tx_len == 7'd60, "R4 write frame length", 64'(tx_len), 64'd60);
                    chk(tx_frame[35:4] == v.wdata, "R4 write data field", 64'(tx_frame[35:4]), 64'(v.wdata));
                end
            end else if (f == 1 || f == nf - 1) begin
                chk(tx_len == 7'd5 && tx_frame[63:59] == 5'b00010, "R6 poll frame",
                    {57'(tx_len), tx_frame[63:59], 2'b0}, {57'd5, 5'b00010, 2'b0});
            end
            @(negedge clk);
            chk(tx_start == 1'b0, "R5 tx_start one cycle", 64'(tx_start), 64'd0);
            @(negedge clk);
            chk(rx_start == 1'b0, "R5 no rx_start before tx_done", 64'(rx_start), 64'd0);
            tx_done = 1'b1;
            @(negedge clk);
            tx_done = 1'b0;
            chk(rx_start == 1'b1, "R5 rx_start after tx_done", 64'(rx_start), 64'd1);
            chk(rx_len == (v.rd ? 6'd32 : 6'd0), v.rd ? "R3 read rx_len" : "R4 write rx_len",
                64'(rx_len), v.rd ? 64'd32 : 64'd0);
            @(negedge clk);
            rx_status = (f < int'(v.nbusy)) ? 3'd1 : v.fin;
            rx_data   = v.rdata;
            rx_done   = 1'b1;
            @(negedge clk);
            rx_done = 1'b0;
        end
        extra_tx = 0;
        for (int w = 0; w < 20 && !rsp_done; w++) begin
            if (tx_start) extra_tx++;
            @(negedge clk);
        end
        chk(rsp_done == 1'b1 && extra_tx == 0, "R8 ends with no further frame",
            64'(extra_tx), 64'd0);
        chk(rsp_status == exp_st, (v.nbusy > MAXP) ? "R7 busy after poll limit" : "R8 final status",
            64'(rsp_status), 64'(exp_st));
        chk(rsp_data == exp_dat, "R9 response data", 64'(rsp_data), 64'(exp_dat));
        chk(rsp_err == (exp_st != 3'd0), "R10 error flag", 64'(rsp_err), 64'(exp_st != 3'd0));
        @(negedge clk);
        chk(rsp_done == 1'b0 && req_ready == 1'b1, "R1 ready after done",
            {62'd0, rsp_done, req_ready}, 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
        chk(tx_start == 1'b0 && rx_start == 1'b0 && rsp_done == 1'b0, "R5 reset quiet",
            {61'd0, tx_start, rx_start, rsp_done}, 64'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run_xact(VECS[i]);
        // R7: exactly MAX_POLLS busy replies then ack still succeeds
        run_xact('{1'b1, 23'h0ABCDE, 32'h0, 10'd512, 3'd0, 32'h0BADCAFE});
        // R7: busy beyond the limit ends as busy
        run_xact('{1'b0, 23'h155555, 32'hA5A5A5A5, 10'd600, 3'd0, 32'h0});
        // R1: request held low while idle starts nothing
        repeat (5) @(negedge clk);
        chk(tx_start == 1'b0 && req_ready == 1'b1, "R1 idle without request",
            {62'd0, tx_start, req_ready}, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule